// File: doc/BRIEF.md
# Dual-Sided Processor Mailbox

This block joins two processors, side A and side B, through a set of one-word mailbox slots. Each direction owns four slots. A word that one side writes into its transmit slot n is held until the other side reads receive slot n. Each side has its own register bank on a small 32-bit register bus, which has a select, a write enable, a 4-bit word address, write data and combinational read data. Each side reads a status word, which shows which of its transmit slots are free, which of its receive slots hold a word, and which doorbell requests from the peer are pending. Each side also has a control word, which holds the interrupt enables, the doorbell request bits and three flag bits that the peer can see.

A message longer than one word rotates through the slots. Word k of the message goes to slot k mod 4, and the first word, which carries the size, goes to slot 0. Every slot keeps its own data and handshake, so the order of words within each slot is kept when the sender laps the slots.

Each slot is a two-state machine, SLOT_EMPTY and SLOT_FULL. A push moves it from SLOT_EMPTY to SLOT_FULL (transition DEPOSIT). A push while it is in SLOT_FULL keeps it there (OVERWRITE). A pop with no push moves it back to SLOT_EMPTY (DRAIN). A pop and a push in the same cycle keep it in SLOT_FULL (REFILL). Each doorbell is a two-state machine, DB_IDLE and DB_PEND. A ring moves it to DB_PEND (RING). An acknowledge with no ring moves it to DB_IDLE (CLEAR). An acknowledge and a ring in the same cycle keep it in DB_PEND (RE-RING).

Top module: `mu_top`

## Requirements
- R1: After reset, both sides read status 0x00F00000 (all transmit slots free, nothing received, nothing pending, flags 0), read control 0, and hold irq at 0.
- R2: Word address map per side: 0..3 transmit slots (write only, they read 0), 4..7 receive slots (read only, writes have no effect), 8 status, 9 control. Addresses 10..15 read 0 and writes to them change nothing.
- R3: A write to transmit slot n clears status bit 23-n on the writing side. From the next cycle on, the peer's status bit 27-n is 1 and its receive address 4+n returns the word.
- R4: A read of receive address 4+n clears the reader's status bit 27-n and sets status bit 23-n again on the peer, from the next cycle.
- R5: Each slot holds its own word. Rotating a multi-word message over slots 0..3, with the sender refilling slot 0 after it has been drained, delivers every word in order.
- R6: A write to a slot that is already full replaces the stored word without error, and neither side's flags change.
- R7: If a slot is written and read in the same cycle, the reader gets the old word and the slot stays full with the new word.
- R8: Control bits 31:20 (general enables 31-n, receive enables 27-n, transmit enables 23-n) and bits 2:0 can be read back as written. Writing 1 to control bit 19-n rings doorbell n of the peer, which shows as peer status bit 31-n. The ringing side reads control bit 19-n as 1 while that doorbell is pending. The peer clears it by writing 1 to its status bit 31-n.
- R9: Control bits 2:0 written on one side read back in bits 2:0 of the peer's status.
- R10: A side's irq is the OR of status bits 31:20 ANDed with the same control bits. With every enable clear, irq stays 0.
- R11: A doorbell rung and acknowledged in the same cycle stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel | input | 1 | Side A bus access strobe |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 4 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational |
| a_irq | output | 1 | Side A interrupt |
| b_sel | input | 1 | Side B bus access strobe |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 4 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, combinational |
| b_irq | output | 1 | Side B interrupt |

## Verification
The situations that are hardest to reach are those where both sides touch the same resource in the same cycle. These are a push and a pop on one slot (REFILL), and a doorbell ring that arrives together with its acknowledge (RE-RING). A bench that drives the sides one after the other never produces them. Directed phases therefore drive both buses on the same clock edge. A long random phase then mixes pushes, pops, control and status writes and stray addresses on either side, and checks every read and irq level against a model of the slots, doorbells and control words kept in the bench.

// File: rtl/mu_pkg.sv
package mu_pkg;
    localparam int REG_W     = 32;
    localparam int FLAG_W    = 3;
    // status / control field tops; slot n sits at top-n
    localparam int GP_TOP    = 31;
    localparam int RF_TOP    = 27;
    localparam int TE_TOP    = 23;
    localparam int GIR_TOP   = 19;
    localparam int OFS_TX0   = 0;
    localparam int OFS_RX0   = 4;
    localparam int OFS_STAT  = 8;
    localparam int OFS_CTRL  = 9;
    localparam logic [REG_W-1:0] STORE_MASK = 32'hFFF0_0007;

    typedef enum logic {SLOT_EMPTY, SLOT_FULL} slot_state_e;
    typedef enum logic {DB_IDLE, DB_PEND} db_state_e;
endpackage

// File: rtl/mu_slot.sv
module mu_slot
    import mu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              empty,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    slot_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (push) state_d = SLOT_FULL;          // DEPOSIT
            SLOT_FULL:  if (pop && !push) state_d = SLOT_EMPTY; // DRAIN; else OVERWRITE/REFILL
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SLOT_EMPTY: begin empty = 1'b1; full = 1'b0; end
            SLOT_FULL:  begin empty = 1'b0; full = 1'b1; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data <= '0;
        else if (push) data <= push_data;
    end
endmodule

// File: rtl/mu_doorbell.sv
module mu_doorbell
    import mu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ring,
    input  logic ack,
    output logic pending
);
    db_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DB_IDLE: if (ring) state_d = DB_PEND;          // RING
            DB_PEND: if (ack && !ring) state_d = DB_IDLE;  // CLEAR; else RE-RING
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            DB_IDLE: pending = 1'b0;
            DB_PEND: pending = 1'b1;
        endcase
    end
endmodule

// File: rtl/mu_side_regs.sv
module mu_side_regs
    import mu_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sel,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [REG_W-1:0]                  wdata,
    output logic [REG_W-1:0]                  rdata,
    input  logic [NUM_SLOTS-1:0]              tx_empty,
    input  logic [NUM_SLOTS-1:0]              rx_full,
    input  logic [NUM_SLOTS-1:0][REG_W-1:0]   rx_data,
    input  logic [NUM_SLOTS-1:0]              gi_pend,
    input  logic [NUM_SLOTS-1:0]              gi_peer_pend,
    input  logic [FLAG_W-1:0]                 peer_flags,
    output logic [NUM_SLOTS-1:0]              push,
    output logic [NUM_SLOTS-1:0]              pop,
    output logic [NUM_SLOTS-1:0]              ring,
    output logic [NUM_SLOTS-1:0]              ack,
    output logic [REG_W-1:0]                  ctrl,
    output logic                              irq
);
    localparam int IRQ_LO = TE_TOP - NUM_SLOTS + 1;

    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] status;
    logic [REG_W-1:0] ctrl_view;
    logic             wr_stat;
    logic             wr_ctrl;

    assign wr_stat = sel && we && (addr == ADDR_W'(OFS_STAT));
    assign wr_ctrl = sel && we && (addr == ADDR_W'(OFS_CTRL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wdata & STORE_MASK;
    end
    assign ctrl = ctrl_q;

    always_comb begin
        status = '0;
        for (int n = 0; n < NUM_SLOTS; n++) begin
            status[TE_TOP - n] = tx_empty[n];
            status[RF_TOP - n] = rx_full[n];
            status[GP_TOP - n] = gi_pend[n];
        end
        status[FLAG_W-1:0] = peer_flags;
    end

    always_comb begin
        ctrl_view = ctrl_q;
        for (int n = 0; n < NUM_SLOTS; n++)
            ctrl_view[GIR_TOP - n] = gi_peer_pend[n];
    end

    always_comb begin
        for (int n = 0; n < NUM_SLOTS; n++) begin
            push[n] = sel && we  && (addr == ADDR_W'(OFS_TX0 + n));
            pop[n]  = sel && !we && (addr == ADDR_W'(OFS_RX0 + n));
            ring[n] = wr_ctrl && wdata[GIR_TOP - n];
            ack[n]  = wr_stat && wdata[GP_TOP - n];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_STAT)) rdata = status;
        if (addr == ADDR_W'(OFS_CTRL)) rdata = ctrl_view;
        for (int n = 0; n < NUM_SLOTS; n++)
            if (addr == ADDR_W'(OFS_RX0 + n)) rdata = rx_data[n];
    end

    assign irq = |(status[GP_TOP:IRQ_LO] & ctrl_q[GP_TOP:IRQ_LO]);
endmodule

// File: rtl/mu_top.sv
module mu_top
    import mu_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_sel,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [REG_W-1:0]  a_wdata,
    output logic [REG_W-1:0]  a_rdata,
    output logic              a_irq,
    input  logic              b_sel,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [REG_W-1:0]  b_wdata,
    output logic [REG_W-1:0]  b_rdata,
    output logic              b_irq
);
    logic [NUM_SLOTS-1:0]            ab_empty, ab_full, ba_empty, ba_full;
    logic [NUM_SLOTS-1:0][REG_W-1:0] ab_data, ba_data;
    logic [NUM_SLOTS-1:0]            a_push, a_pop, a_ring, a_ack, a_pend;
    logic [NUM_SLOTS-1:0]            b_push, b_pop, b_ring, b_ack, b_pend;
    logic [REG_W-1:0]                a_ctrl, b_ctrl;

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_lane
        mu_slot #(.DATA_W(REG_W)) u_ab (
            .clk(clk), .rst_n(rst_n), .push(a_push[n]), .push_data(a_wdata),
            .pop(b_pop[n]), .empty(ab_empty[n]), .full(ab_full[n]), .data(ab_data[n]));
        mu_slot #(.DATA_W(REG_W)) u_ba (
            .clk(clk), .rst_n(rst_n), .push(b_push[n]), .push_data(b_wdata),
            .pop(a_pop[n]), .empty(ba_empty[n]), .full(ba_full[n]), .data(ba_data[n]));
        mu_doorbell u_db_b (
            .clk(clk), .rst_n(rst_n), .ring(a_ring[n]), .ack(b_ack[n]), .pending(b_pend[n]));
        mu_doorbell u_db_a (
            .clk(clk), .rst_n(rst_n), .ring(b_ring[n]), .ack(a_ack[n]), .pending(a_pend[n]));
    end

    mu_side_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_side_a (
        .clk(clk), .rst_n(rst_n), .sel(a_sel), .we(a_we), .addr(a_addr),
        .wdata(a_wdata), .rdata(a_rdata), .tx_empty(ab_empty), .rx_full(ba_full),
        .rx_data(ba_data), .gi_pend(a_pend), .gi_peer_pend(b_pend),
        .peer_flags(b_ctrl[FLAG_W-1:0]), .push(a_push), .pop(a_pop),
        .ring(a_ring), .ack(a_ack), .ctrl(a_ctrl), .irq(a_irq));

    mu_side_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_side_b (
        .clk(clk), .rst_n(rst_n), .sel(b_sel), .we(b_we), .addr(b_addr),
        .wdata(b_wdata), .rdata(b_rdata), .tx_empty(ba_empty), .rx_full(ab_full),
        .rx_data(ab_data), .gi_pend(b_pend), .gi_peer_pend(a_pend),
        .peer_flags(a_ctrl[FLAG_W-1:0]), .push(b_push), .pop(b_pop),
        .ring(b_ring), .ack(b_ack), .ctrl(b_ctrl), .irq(b_irq));
endmodule

// File: rtl/mu_top_chk.sv
module mu_top_chk #(
    parameter int NUM_SLOTS = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SLOTS-1:0]       ab_empty, ab_full, ba_empty, ba_full,
    input logic [NUM_SLOTS-1:0][31:0] ab_data, ba_data,
    input logic [NUM_SLOTS-1:0]       a_push, a_pop, a_ring, a_ack, a_pend,
    input logic [NUM_SLOTS-1:0]       b_push, b_pop, b_ring, b_ack, b_pend,
    input logic [31:0]                a_ctrl, b_ctrl,
    input logic                       a_irq, b_irq
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&ab_empty && &ba_empty && !(|ab_full) && !(|ba_full)
                          && !(|a_pend) && !(|b_pend)));

    p_irq_quiet_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ctrl[31:20] == 12'h000) |-> !a_irq);
    p_irq_quiet_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (b_ctrl[31:20] == 12'h000) |-> !b_irq);

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_chk
        p_push_fills_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
            a_push[n] |=> (ab_full[n] && !ab_empty[n]));
        p_push_fills_ba_r3: assert property (@(posedge clk) disable iff (!rst_n)
            b_push[n] |=> (ba_full[n] && !ba_empty[n]));
        p_pop_drains_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (b_pop[n] && !a_push[n]) |=> (ab_empty[n] && !ab_full[n]));
        p_pop_drains_ba_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (a_pop[n] && !b_push[n]) |=> (ba_empty[n] && !ba_full[n]));
        p_word_held_ab_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !a_push[n] |=> $stable(ab_data[n]));
        p_word_held_ba_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !b_push[n] |=> $stable(ba_data[n]));
        p_refill_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (a_push[n] && b_pop[n]) |=> ab_full[n]);
        p_ring_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
            a_ring[n] |=> b_pend[n]);
        p_ring_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
            b_ring[n] |=> a_pend[n]);
        p_ack_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (b_ack[n] && !a_ring[n]) |=> !b_pend[n]);
        p_ring_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (b_ack[n] && a_ring[n]) |=> b_pend[n]);
    end
endmodule

bind mu_top mu_top_chk #(.NUM_SLOTS(NUM_SLOTS)) u_mu_top_chk (
    .clk(clk), .rst_n(rst_n),
    .ab_empty(ab_empty), .ab_full(ab_full), .ba_empty(ba_empty), .ba_full(ba_full),
    .ab_data(ab_data), .ba_data(ba_data),
    .a_push(a_push), .a_pop(a_pop), .a_ring(a_ring), .a_ack(a_ack), .a_pend(a_pend),
    .b_push(b_push), .b_pop(b_pop), .b_ring(b_ring), .b_ack(b_ack), .b_pend(b_pend),
    .a_ctrl(a_ctrl), .b_ctrl(b_ctrl), .a_irq(a_irq), .b_irq(b_irq));

// File: tb/test_mu_top.sv
`timescale 1ns/1ps
module test_mu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_sel = 0, a_we = 0, b_sel = 0, b_we = 0;
    logic [3:0]  a_addr = 0, b_addr = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int vectors = 0;
    int errors  = 0;

    // bench model: direction s means written by side s
    bit          full_m [2][4];
    logic [31:0] dat_m  [2][4];
    bit          pend_m [2][4];   // doorbell pending on side s
    logic [31:0] ctrl_m [2];

    always #2.5 clk = ~clk;

    mu_top i_mu_top (
        .clk(clk), .rst_n(rst_n),
        .a_sel(a_sel), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_sel(b_sel), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq));

    function automatic logic [31:0] exp_status(int s);
        logic [31:0] v = '0;
        for (int n = 0; n < 4; n++) begin
            v[23-n] = !full_m[s][n];
            v[27-n] = full_m[1-s][n];
            v[31-n] = pend_m[s][n];
        end
        v[2:0] = ctrl_m[1-s][2:0];
        return v;
    endfunction

    function automatic logic [31:0] exp_ctrl(int s);
        logic [31:0] v = ctrl_m[s];
        for (int n = 0; n < 4; n++) v[19-n] = pend_m[1-s][n];
        return v;
    endfunction

    function automatic logic [31:0] exp_read(int s, int a);
        if (a >= 4 && a <= 7) return dat_m[1-s][a-4];
        if (a == 8) return exp_status(s);
        if (a == 9) return exp_ctrl(s);
        return 32'h0;
    endfunction

    function automatic bit exp_irq(int s);
        logic [31:0] st = exp_status(s);
        return |(st[31:20] & ctrl_m[s][31:20]);
    endfunction

    function automatic void model_write(int s, int a, logic [31:0] d);
        if (a < 4) begin full_m[s][a] = 1; dat_m[s][a] = d; end
        else if (a == 8) begin
            for (int n = 0; n < 4; n++) if (d[31-n]) pend_m[s][n] = 0;
        end else if (a == 9) begin
            ctrl_m[s] = d & 32'hFFF0_0007;
            for (int n = 0; n < 4; n++) if (d[19-n]) pend_m[1-s][n] = 1;
        end
    endfunction

    function automatic void model_read(int s, int a);
        if (a >= 4 && a <= 7) full_m[1-s][a-4] = 0;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(int s, bit w, int a, logic [31:0] d);
        if (s == 0) begin a_sel = 1; a_we = w; a_addr = 4'(a); a_wdata = d; end
        else        begin b_sel = 1; b_we = w; b_addr = 4'(a); b_wdata = d; end
    endtask

    task automatic idle();
        a_sel = 0; a_we = 0; b_sel = 0; b_we = 0;
    endtask

    task automatic bus_write(int s, int a, logic [31:0] d);
        @(negedge clk);
        drive(s, 1, a, d);
        @(posedge clk);
        #1 idle();
        model_write(s, a, d);
    endtask

    task automatic bus_read(int s, int a, string req);
        logic [31:0] got;
        @(negedge clk);
        drive(s, 0, a, 32'h0);
        #1;
        got = (s == 0) ? a_rdata : b_rdata;
        check(req, got, exp_read(s, a));
        check({req, " irq"}, {31'h0, (s == 0) ? a_irq : b_irq}, {31'h0, exp_irq(s)});
        @(posedge clk);
        #1 idle();
        model_read(s, a);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] got;
        void'($urandom(32'h1d2c3b4a));
        for (int s = 0; s < 2; s++) begin
            ctrl_m[s] = '0;
            for (int n = 0; n < 4; n++) begin
                full_m[s][n] = 0; dat_m[s][n] = '0; pend_m[s][n] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        bus_read(0, 8, "R1 status A");
        bus_read(1, 8, "R1 status B");
        bus_read(0, 9, "R1 ctrl A");
        bus_read(1, 9, "R1 ctrl B");

        // R3/R5 rotating message A->B with lap
        for (int k = 0; k < 4; k++) bus_write(0, k, 32'hA000_0000 + k);
        bus_read(0, 8, "R3 sender status");
        bus_read(1, 8, "R3 receiver status");
        bus_read(1, 4, "R5 word0");
        bus_read(0, 8, "R4 slot0 free again");
        bus_write(0, 0, 32'hA000_0004);
        for (int k = 1; k < 4; k++) bus_read(1, 4 + k, "R5 words1-3");
        bus_read(1, 4, "R5 word4 lapped");
        bus_read(1, 8, "R4 receiver drained");

        // R6 overwrite of full slot
        bus_write(1, 2, 32'h1111_2222);
        bus_write(1, 2, 32'h3333_4444);
        bus_read(0, 8, "R6 status after overwrite");
        bus_read(0, 6, "R6 newest word");

        // R7 write and read of one slot in the same cycle
        bus_write(0, 1, 32'hDEAD_0001);
        @(negedge clk);
        drive(0, 1, 1, 32'hBEEF_0002);
        drive(1, 0, 5, 32'h0);
        #1 got = b_rdata;
        check("R7 reader sees old word", got, 32'hDEAD_0001);
        @(posedge clk);
        #1 idle();
        model_read(1, 5);
        model_write(0, 1, 32'hBEEF_0002);
        bus_read(1, 8, "R7 slot stays full");
        bus_read(1, 5, "R7 new word");

        // R8 doorbell ring and clear
        bus_write(0, 9, 32'h0008_0000);
        bus_read(1, 8, "R8 peer pending");
        bus_read(0, 9, "R8 ringer sees request");
        bus_write(1, 8, 32'h8000_0000);
        bus_read(1, 8, "R8 cleared");
        bus_read(0, 9, "R8 request dropped");

        // R11 ring and ack together
        bus_write(0, 9, 32'h0004_0000);
        @(negedge clk);
        drive(0, 1, 9, 32'h0004_0000);
        drive(1, 1, 8, 32'h4000_0000);
        @(posedge clk);
        #1 idle();
        model_write(1, 8, 32'h4000_0000);
        model_write(0, 9, 32'h0004_0000);
        bus_read(1, 8, "R11 still pending");

        // R9 flags
        bus_write(0, 9, 32'h0000_0005);
        bus_read(1, 8, "R9 flags at peer");

        // R10 interrupt by receive enable
        bus_write(1, 9, 32'h0800_0000);
        bus_write(0, 0, 32'h5A5A_5A5A);
        bus_read(1, 9, "R10 ctrl readback");
        bus_read(1, 4, "R10 irq while full");
        bus_read(1, 8, "R10 irq after drain");

        // R2 stray and read-only addresses
        bus_write(0, 12, 32'hFFFF_FFFF);
        bus_write(1, 6, 32'hFFFF_FFFF);
        bus_read(0, 12, "R2 unmapped");
        bus_read(0, 2, "R2 tx reads zero");
        bus_read(1, 8, "R2 status unchanged");

        // random mix
        for (int i = 0; i < 1500; i++) begin
            int s = $urandom_range(0, 1);
            int op = $urandom_range(0, 9);
            int a;
            logic [31:0] d = $urandom;
            if (op < 3)      bus_write(s, $urandom_range(0, 3), d);
            else if (op < 7) bus_read(s, $urandom_range(0, 15), "R5 random read");
            else if (op == 7) bus_write(s, 9, d & ($urandom_range(0, 1) ? 32'hFFFF_FFFF : 32'h0008_0007));
            else if (op == 8) bus_write(s, 8, d);
            else begin
                a = $urandom_range(4, 15);
                if (a == 8 || a == 9) a = 10;
                bus_write(s, a, d);
            end
        end
        bus_read(0, 8, "R10 final status A");
        bus_read(1, 8, "R10 final status B");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule